// File: doc/BRIEF.md
# Log-Domain Galois Field Multiplier

This block multiplies two elements of GF(2^m), with m set to 10 or 11 by parameter. It does not use a polynomial multiplier array. It turns each nonzero operand into its discrete logarithm, adds the two logarithms modulo 2^m−1, and turns the sum back into a field element with an antilogarithm table.

Both tables are built inside the block from a parameterised primitive polynomial. They are filled by stepping the generator element from 1 through every nonzero value. No table content is loaded from outside.

The modular add uses an end-around carry. Its result may stay at 2^m−1, which stands for 0, and is not corrected. The antilogarithm table maps both index 0 and index 2^m−1 to the element 1. An operand equal to zero sets a flag that travels with the data and forces the product to zero.

The block is a three-stage pipeline:
1. Logarithm lookup.
2. Modular add.
3. Antilogarithm lookup.

It accepts one operand pair per clock and marks each result with a valid flag.

Top module: `gflog_mult`

## Requirements
- R1: For nonzero operands, `product` equals the field product: the shift-and-xor polynomial multiply of `op_a` and `op_b`, reduced by x^M plus the terms in `POLY_TAPS`. The defaults are M=10 and x^10+x^3+1, so `POLY_TAPS`=0x009 and bit i of an operand is the coefficient of x^i.
- R2: A pair presented with `in_valid` high before clock edge n gives `out_valid` high, with its product on `product`, after edge n+2. That is three register stages, and `out_valid` is low in the cycles before.
- R3: If either operand is zero, `product` is zero in the cycle its `out_valid` is high.
- R4: Multiplying by the element 1 returns the other operand unchanged.
- R5: When the two logarithms sum to exactly 2^M−1, the product is the element 1. This covers an operand times its inverse.
- R6: When the two logarithms sum to more than 2^M−1, the sum wraps modulo 2^M−1. For example, x^1000 times x^1000 equals x^977 for M=10.
- R7: While `rst_n` is low and after it rises, `out_valid` is low and `product` is zero. A pair in flight when reset is asserted never appears at the output.
- R8: Pairs may arrive on consecutive cycles or with idle gaps. Each produces exactly one result, in arrival order, and gaps stay gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid |
| op_a | input | M | First field element |
| op_b | input | M | Second field element |
| out_valid | output | 1 | `product` holds a result |
| product | output | M | Field product of the pair accepted three cycles earlier |

## Verification
Fixed operand pairs and a pseudo-random stream are compared against a shift-and-xor reference multiply. A wrong table or a wrong reduction polynomial shows up there.

Pairs of generator powers whose logarithms sum to exactly 2^M−1 test the unnormalised all-ones index. Pairs whose logarithms exceed 2^M−1 test the end-around carry. Together these separate a correct wrap from an off-by-one modulus.

Zero operands, the element 1, single isolated pulses, bubbled streams and a reset during flight separate zero handling, identity, latency and pipeline ordering.

// File: rtl/gflog_pkg.sv
package gflog_pkg;

  // Multiply a field element by x, reducing by x^m + taps.
  function automatic int gf_xtime(int x, int m, int taps);
    int y;
    y = x << 1;
    if (((y >> m) & 1) == 1) y = (y ^ taps) & ((1 << m) - 1);
    return y;
  endfunction

  // Modulo (2^m - 1) add with end-around carry; may return 2^m - 1 for zero.
  function automatic int eac_add(int a, int b, int m);
    int s;
    s = a + b;
    return (s & ((1 << m) - 1)) + (s >> m);
  endfunction

endpackage

// File: rtl/gflog_rom.sv
module gflog_rom #(
  parameter int M         = 10,
  parameter int POLY_TAPS = 'h009,
  parameter bit IS_LOG    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [M-1:0] addr,
  output logic [M-1:0] data
);
  import gflog_pkg::*;

  localparam int N = 1 << M;

  logic [M-1:0] tab [N];

  generate
    if (IS_LOG) begin : g_log
      always_comb begin
        logic [M-1:0] x;
        for (int i = 0; i < N; i++) tab[i] = '0;
        x = M'(1);
        for (int k = 0; k < N - 1; k++) begin
          tab[x] = M'(k);
          x = M'(gf_xtime(int'(x), M, POLY_TAPS));
        end
      end
    end else begin : g_alog
      always_comb begin
        logic [M-1:0] x;
        x = M'(1);
        for (int k = 0; k < N - 1; k++) begin
          tab[k] = x;
          x = M'(gf_xtime(int'(x), M, POLY_TAPS));
        end
        tab[N-1] = M'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= tab[addr];
  end
endmodule

// File: rtl/gflog_modadd.sv
module gflog_modadd #(
  parameter int M = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [M-1:0] log_a,
  input  logic [M-1:0] log_b,
  output logic [M-1:0] sum
);
  import gflog_pkg::*;

  logic [M-1:0] sum_d;

  always_comb sum_d = M'(eac_add(int'(log_a), int'(log_b), M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= '0;
    else        sum <= sum_d;
  end
endmodule

// File: rtl/gflog_mult.sv
module gflog_mult #(
  parameter int M         = 10,
  parameter int POLY_TAPS = 'h009
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         out_valid,
  output logic [M-1:0] product
);
  // stage 1: log lookup
  logic         s1_valid, s1_zero;
  logic [M-1:0] s1_log_a, s1_log_b;
  // stage 2: modulo add
  logic         s2_valid, s2_zero;
  logic [M-1:0] s2_sum;
  // stage 3: antilog lookup
  logic         s3_valid, s3_zero;
  logic [M-1:0] s3_alog;
  logic         in_zero;

  assign in_zero = (op_a == '0) || (op_b == '0);

  gflog_rom #(.M(M), .POLY_TAPS(POLY_TAPS), .IS_LOG(1'b1)) u_log_a (
    .clk(clk), .rst_n(rst_n), .addr(op_a), .data(s1_log_a));
  gflog_rom #(.M(M), .POLY_TAPS(POLY_TAPS), .IS_LOG(1'b1)) u_log_b (
    .clk(clk), .rst_n(rst_n), .addr(op_b), .data(s1_log_b));

  gflog_modadd #(.M(M)) u_add (
    .clk(clk), .rst_n(rst_n), .log_a(s1_log_a), .log_b(s1_log_b), .sum(s2_sum));

  gflog_rom #(.M(M), .POLY_TAPS(POLY_TAPS), .IS_LOG(1'b0)) u_alog (
    .clk(clk), .rst_n(rst_n), .addr(s2_sum), .data(s3_alog));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_zero <= 1'b0;
      s2_valid <= 1'b0; s2_zero <= 1'b0;
      s3_valid <= 1'b0; s3_zero <= 1'b1;
    end else begin
      s1_valid <= in_valid; s1_zero <= in_zero;
      s2_valid <= s1_valid; s2_zero <= s1_zero;
      s3_valid <= s2_valid; s3_zero <= s2_zero;
    end
  end

  assign out_valid = s3_valid;
  assign product   = s3_zero ? '0 : s3_alog;
endmodule

// File: rtl/gflog_mult_chk.sv
module gflog_mult_chk #(
  parameter int M = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         s1_valid,
  input logic         s1_zero,
  input logic [M-1:0] s1_log_a,
  input logic [M-1:0] s1_log_b,
  input logic         s2_valid,
  input logic         s2_zero,
  input logic         out_valid,
  input logic [M-1:0] product
);
  AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);                                   // R2
  AST_STAGE2_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);                                   // R2
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid);                                  // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s2_valid));                           // R8
  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_zero) |=> (product == '0));               // R3
  AST_NONZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_zero) |=> (product != '0));              // R1
  AST_LOG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_zero) |-> (s1_log_a != '1 && s1_log_b != '1)); // R1
endmodule

bind gflog_mult gflog_mult_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .s1_valid(s1_valid), .s1_zero(s1_zero),
  .s1_log_a(s1_log_a), .s1_log_b(s1_log_b),
  .s2_valid(s2_valid), .s2_zero(s2_zero),
  .out_valid(out_valid), .product(product));

// File: tb/test_gflog_mult.sv
module test_gflog_mult;
  localparam int M    = 10;
  localparam int TAPS = 'h009;
  localparam int NV   = 12;
  localparam logic [M-1:0] VEC_A [NV] = '{10'h001, 10'h002, 10'h3FF, 10'h123,
    10'h200, 10'h055, 10'h3FE, 10'h100, 10'h1A5, 10'h2F0, 10'h3C3, 10'h070};
  localparam logic [M-1:0] VEC_B [NV] = '{10'h2AB, 10'h200, 10'h3FF, 10'h321,
    10'h200, 10'h0AA, 10'h001, 10'h004, 10'h05A, 10'h00F, 10'h18E, 10'h307};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [M-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [M-1:0] product;

  int errors = 0;
  int checks = 0;
  logic [M-1:0] exp_mem [256];
  string exp_req [256];
  int wr = 0, rd = 0;

  always #4 clk = ~clk;

  gflog_mult #(.M(M), .POLY_TAPS(TAPS)) i_gflog_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product));

  function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] p;
    p = '0;
    for (int i = M - 1; i >= 0; i--) begin
      p = {p[M-2:0], 1'b0} ^ (p[M-1] ? M'(TAPS) : '0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [M-1:0] ref_pow(int e);
    logic [M-1:0] p;
    p = M'(1);
    for (int i = 0; i < e; i++) p = ref_mul(p, M'(2));
    return p;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [M-1:0] a, input logic [M-1:0] b, input string req);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    exp_mem[wr % 256] = ref_mul(a, b);
    exp_req[wr % 256] = req;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = '0; op_b = '0;
    end
  endtask

  // scoreboard: every result in order
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd == wr) begin
        checks++; errors++;
        $display("FAIL R8: unexpected result actual=%h expected=none", product);
      end else begin
        check(exp_req[rd % 256], product, exp_mem[rd % 256]);
        rd++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [M-1:0] ra, rb;
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 valid in reset", M'(out_valid), '0);
    check("R7 product in reset", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 valid after reset", M'(out_valid), '0);

    // R1: vector table, back to back
    for (int i = 0; i < NV; i++) push(VEC_A[i], VEC_B[i], "R1 table");
    idle(5);

    // R2: single pulse latency
    push(10'h0F3, 10'h1C2, "R2 data");
    @(negedge clk); in_valid = 1'b0;
    check("R2 cycle1", M'(out_valid), '0);
    @(negedge clk);
    check("R2 cycle2", M'(out_valid), '0);
    @(negedge clk);
    check("R2 cycle3", M'(out_valid), M'(1));
    @(negedge clk);
    check("R2 cycle4", M'(out_valid), '0);

    // R3: zero operands
    push(10'h000, 10'h2AB, "R3 a zero");
    push(10'h155, 10'h000, "R3 b zero");
    push(10'h000, 10'h000, "R3 both zero");
    push(10'h000, 10'h001, "R3 zero times one");
    // R4: identity
    push(10'h001, 10'h3A7, "R4 one left");
    push(10'h28C, 10'h001, "R4 one right");
    push(10'h001, 10'h001, "R4 one times one");
    // R5: logs sum to all ones
    push(ref_pow(1), ref_pow(1022), "R5 x times inverse");
    push(ref_pow(500), ref_pow(523), "R5 mid inverse");
    push(ref_pow(1022), ref_pow(1), "R5 swapped");
    // R6: wrap past modulus
    push(ref_pow(1000), ref_pow(1000), "R6 wrap 977");
    push(ref_pow(1022), ref_pow(1022), "R6 max logs");
    push(ref_pow(600), ref_pow(424), "R6 just past");
    idle(5);
    check("R6 pow ref", ref_mul(ref_pow(1000), ref_pow(1000)), ref_pow(977));

    // R8: bubbled stream and random pairs
    ra = 10'h2C5; rb = 10'h117;
    for (int i = 0; i < 60; i++) begin
      ra = {ra[M-2:0], ra[M-1] ^ ra[6]};
      rb = {rb[M-2:0], rb[M-1] ^ rb[2]} ^ M'(i);
      if (i % 5 == 3) idle(1 + (i % 3));
      push(ra, rb, "R8 stream");
    end
    idle(6);
    check("R8 all results out", M'(wr - rd), '0);

    // R7: reset with data in flight
    push(10'h1FF, 10'h0F0, "R7 flight");
    @(negedge clk); in_valid = 1'b0;
    rst_n = 1'b0;
    rd = wr;
    @(negedge clk);
    check("R7 flush valid", M'(out_valid), '0);
    check("R7 flush product", product, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no stale output", M'(out_valid), '0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule